// File: doc/BRIEF.md
# Aperture Remapping Address Translator

This block sits between a device-facing bus and system memory. It turns 32-bit device bus addresses that land inside a configurable remapping window into 40-bit physical addresses. The mapping is held in a table of 32-bit page entries stored in memory. Software programs three configuration registers: a control word carrying the enable bit and the window size order, the window base, and the table base. For each request the block checks the address against the window and works out the page index. It looks the page up in a small translation cache. On a miss it reads the page entry through a single-outstanding memory read port. It then answers with either a translated address or a fault.

Pages are 4 KiB and the low 12 address bits pass through unchanged. A page entry carries physical address bits 31:12 in entry bits 31:12 and physical bits 39:32 in entry bits 11:4. Entry bit 1 is a coherent flag and entry bit 0 marks the entry usable. The cache holds four pages. A one-cycle flush pulse empties it, and so does turning translation off.

Top module: `remap_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid, mem_req_valid and mem_rsp_ready are 0. Every configuration register reads 0.
- R2: Register offsets are control 0x90, window base 0x94 (bits 14:0 kept) and table base 0x98 (bits 31:4 kept, bits 3:0 read 0). Any other offset reads 0. A control write with bit 0 set stores bits 5:4 as 0. A control write with bit 0 clear stores the word as written.
- R3: The window starts at the base field shifted left by 25 and spans 32 MiB shifted left by control bits 3:1. An address below the start, or at or above the end, gives a fault with no memory read.
- R4: The window is unusable when its end lies beyond 4 GiB or when its base field is zero. Every request then faults. A window ending exactly at 4 GiB is usable.
- R5: While control bit 0 is 0, every request faults without a memory read.
- R6: On a miss the entry is read from {table field, 12'b0} + 4 × ((address − window start) >> 12). The read uses a 40-bit word-aligned address.
- R7: A valid entry e gives rsp_paddr = {e[11:4], e[31:12], addr[11:0]} and rsp_coherent = e[1], with rsp_fault 0.
- R8: An entry with bit 0 clear gives rsp_fault 1, rsp_paddr 0 and rsp_coherent 0. Such an entry is not cached.
- R9: Up to four pages with valid entries are cached and answered without a memory read. A fifth distinct page replaces the entries in round-robin fill order.
- R10: A one-cycle flush pulse empties the cache, so the next access to a cached page reads memory again.
- R11: A control write that changes the enable bit from 1 to 0 empties the cache.
- R12: Only one memory read is outstanding at a time. mem_req_valid holds with a stable address until mem_req_ready. A hit or fault answers with rsp_valid one cycle after acceptance. A miss answers one cycle after the memory response is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the register at cfg_addr |
| flush | input | 1 | One-cycle cache invalidate pulse |
| req_valid | input | 1 | Translation request valid |
| req_addr | input | 32 | Device bus address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation refused |
| rsp_coherent | output | 1 | Coherent flag of the used entry |
| rsp_paddr | output | 40 | Translated physical address |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_addr | output | 40 | Physical address of the entry |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry data |
| mem_rsp_ready | output | 1 | Block waits for entry data |

## Verification
The bench aims at the window edges: the first and last byte of the window, one byte either side, and a window ending exactly at 4 GiB. An off-by-one compare would either translate a foreign address or refuse a legal one. Entries with the valid bit clear are used to show that such an entry is neither answered as a translation nor kept in the cache, where a wrong design would return a stale address. Five-page sweeps, flush pulses and enable drops show whether the round-robin fill order and the invalidation rules hold. A wrong design shows this as missing or extra memory reads. Random memory stall lengths make sure a request address that drifts or a second outstanding read is caught.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int PA_W     = 40;
  localparam int BUS_W    = 32;
  localparam int PG_SH    = 12;
  localparam int VPN_W    = BUS_W - PG_SH;
  localparam int ORD_W    = 3;
  localparam int AP_FLD_W = 15;
  localparam int AP_SH    = 25;
  localparam int TB_FLD_W = PA_W - PG_SH;
  localparam int ENT_W    = 32;
  localparam int REG_W    = 32;
  localparam int OFS_W    = 8;

  localparam logic [OFS_W-1:0] OFS_CTRL  = 8'h90;
  localparam logic [OFS_W-1:0] OFS_APWIN = 8'h94;
  localparam logic [OFS_W-1:0] OFS_TBASE = 8'h98;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_WAIT  = 2'd2
  } walk_st_e;

  typedef struct packed {
    logic            fault;
    logic            coh;
    logic [PA_W-1:0] paddr;
  } xl_rsp_t;

  // Builds the response for one page entry and the in-page offset.
  function automatic xl_rsp_t decode_entry(input logic [ENT_W-1:0] e,
                                           input logic [PG_SH-1:0] low);
    xl_rsp_t r;
    r = '0;
    if (e[0]) begin
      r.coh   = e[1];
      r.paddr = {e[11:4], e[31:12], low};
    end else begin
      r.fault = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg
  import remap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [OFS_W-1:0]    cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  output logic                xl_en,
  output logic [ORD_W-1:0]    ap_order,
  output logic [AP_FLD_W-1:0] ap_field,
  output logic [TB_FLD_W-1:0] tb_field,
  output logic                en_drop
);
  logic [REG_W-1:0]    ctrl_q, ctrl_d;
  logic [AP_FLD_W-1:0] ap_q, ap_d;
  logic [TB_FLD_W-1:0] tb_q, tb_d;
  logic                ctrl_wr, ap_wr, tb_wr;

  always_comb begin
    ctrl_wr = cfg_we && (cfg_addr == OFS_CTRL);
    ap_wr   = cfg_we && (cfg_addr == OFS_APWIN);
    tb_wr   = cfg_we && (cfg_addr == OFS_TBASE);
    ctrl_d  = cfg_wdata;
    if (cfg_wdata[0]) ctrl_d[5:4] = 2'b00;
    ap_d    = cfg_wdata[AP_FLD_W-1:0];
    tb_d    = cfg_wdata[REG_W-1:REG_W-TB_FLD_W];
    en_drop = ctrl_wr && ctrl_q[0] && !cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ap_q   <= '0;
      tb_q   <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_d;
      if (ap_wr)   ap_q   <= ap_d;
      if (tb_wr)   tb_q   <= tb_d;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL:  cfg_rdata = ctrl_q;
      OFS_APWIN: cfg_rdata = {{(REG_W-AP_FLD_W){1'b0}}, ap_q};
      OFS_TBASE: cfg_rdata = {tb_q, {(REG_W-TB_FLD_W){1'b0}}};
      default:   cfg_rdata = '0;
    endcase
  end

  assign xl_en    = ctrl_q[0];
  assign ap_order = ctrl_q[ORD_W:1];
  assign ap_field = ap_q;
  assign tb_field = tb_q;
endmodule

// File: rtl/remap_aperture.sv
module remap_aperture
  import remap_pkg::*;
(
  input  logic                xl_en,
  input  logic [ORD_W-1:0]    ap_order,
  input  logic [AP_FLD_W-1:0] ap_field,
  input  logic [BUS_W-1:0]    bus_addr,
  output logic                pass,
  output logic [VPN_W-1:0]    page_idx
);
  localparam int EXT_W = PA_W + 1;
  localparam logic [EXT_W-1:0] LIMIT = EXT_W'(1) << BUS_W;

  logic [EXT_W-1:0] base_x, span_x, end_x, addr_x;
  logic [5:0]       sh;
  logic             win_ok, in_win;

  always_comb begin
    sh       = 6'(AP_SH) + 6'(ap_order);
    base_x   = {1'b0, ap_field, {AP_SH{1'b0}}};
    span_x   = EXT_W'(1) << sh;
    end_x    = base_x + span_x;
    addr_x   = EXT_W'(bus_addr);
    win_ok   = (ap_field != '0) && (end_x <= LIMIT);
    in_win   = (addr_x >= base_x) && (addr_x < end_x);
    pass     = xl_en && win_ok && in_win;
    // base has no bits below AP_SH, so the page subtraction needs no borrow in
    page_idx = bus_addr[BUS_W-1:PG_SH] - base_x[BUS_W-1:PG_SH];
  end
endmodule

// File: rtl/remap_tcache.sv
module remap_tcache #(
  parameter int N_WAYS = 4,
  parameter int TAG_W  = 20,
  parameter int DAT_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [DAT_W-1:0] hit_data,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DAT_W-1:0] fill_data
);
  localparam int PTR_W = (N_WAYS > 1) ? $clog2(N_WAYS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(N_WAYS - 1);

  logic [N_WAYS-1:0] vld_q, vld_d, match;
  logic [PTR_W-1:0]  rr_q, rr_d;
  logic [DAT_W-1:0]  sel_data [N_WAYS];
  logic              do_fill;

  assign do_fill = fill_en && !clear;

  for (genvar g = 0; g < N_WAYS; g++) begin : g_way
    logic [TAG_W-1:0] tag_q;
    logic [DAT_W-1:0] dat_q;
    logic             wr_en;

    assign wr_en       = do_fill && (rr_q == PTR_W'(g));
    assign match[g]    = vld_q[g] && (tag_q == look_tag);
    assign sel_data[g] = match[g] ? dat_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q <= '0;
        dat_q <= '0;
      end else if (wr_en) begin
        tag_q <= fill_tag;
        dat_q <= fill_data;
      end
    end
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < N_WAYS; i++) hit_data = hit_data | sel_data[i];
    hit = |match;
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (clear) begin
      vld_d = '0;
    end else if (do_fill) begin
      vld_d[rr_q] = 1'b1;
      rr_d        = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end
endmodule

// File: rtl/remap_walker.sv
module remap_walker
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  output logic             req_ready,
  input  logic             pass,
  input  logic             hit,
  input  logic [ENT_W-1:0] hit_data,
  input  logic [PA_W-1:0]  ent_addr,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             mem_rsp_ready,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_coherent,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             fill_en,
  output logic [VPN_W-1:0] fill_tag,
  output logic [ENT_W-1:0] fill_data
);
  walk_st_e         st_q, st_d;
  logic [PA_W-1:0]  ea_q;
  logic [PG_SH-1:0] low_q;
  logic [VPN_W-1:0] tag_q;
  xl_rsp_t          rsp_q, rsp_d;
  logic             rsp_v_q, rsp_v_d;
  logic             cap_en, rsp_ld;

  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    rsp_ld  = 1'b0;
    rsp_d   = rsp_q;
    rsp_v_d = 1'b0;
    fill_en = 1'b0;
    case (st_q)
      W_IDLE: begin
        if (req_valid) begin
          if (!pass) begin
            rsp_ld      = 1'b1;
            rsp_d       = '0;
            rsp_d.fault = 1'b1;
            rsp_v_d     = 1'b1;
          end else if (hit) begin
            rsp_ld  = 1'b1;
            rsp_d   = decode_entry(hit_data, req_addr[PG_SH-1:0]);
            rsp_v_d = 1'b1;
          end else begin
            cap_en = 1'b1;
            st_d   = W_FETCH;
          end
        end
      end
      W_FETCH: begin
        if (mem_req_ready) st_d = W_WAIT;
      end
      W_WAIT: begin
        if (mem_rsp_valid) begin
          st_d    = W_IDLE;
          rsp_ld  = 1'b1;
          rsp_d   = decode_entry(mem_rsp_data, low_q);
          rsp_v_d = 1'b1;
          fill_en = mem_rsp_data[0];
        end
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      ea_q    <= '0;
      low_q   <= '0;
      tag_q   <= '0;
      rsp_q   <= '0;
      rsp_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= rsp_v_d;
      if (cap_en) begin
        ea_q  <= ent_addr;
        low_q <= req_addr[PG_SH-1:0];
        tag_q <= req_addr[BUS_W-1:PG_SH];
      end
      if (rsp_ld) rsp_q <= rsp_d;
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign mem_req_valid = (st_q == W_FETCH);
  assign mem_rsp_ready = (st_q == W_WAIT);
  assign mem_req_addr  = ea_q;
  assign rsp_valid     = rsp_v_q;
  assign rsp_fault     = rsp_q.fault;
  assign rsp_coherent  = rsp_q.coh;
  assign rsp_paddr     = rsp_q.paddr;
  assign fill_tag      = tag_q;
  assign fill_data     = mem_rsp_data;
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate
  import remap_pkg::*;
#(
  parameter int N_WAYS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [OFS_W-1:0] cfg_addr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             flush,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic             rsp_coherent,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data,
  output logic             mem_rsp_ready
);
  logic                xl_en, en_drop, pass, hit, fill_en, cache_clr;
  logic [ORD_W-1:0]    ap_order;
  logic [AP_FLD_W-1:0] ap_field;
  logic [TB_FLD_W-1:0] tb_field;
  logic [VPN_W-1:0]    page_idx, fill_tag;
  logic [ENT_W-1:0]    hit_data, fill_data;
  logic [PA_W-1:0]     ent_addr;

  remap_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .xl_en    (xl_en),
    .ap_order (ap_order),
    .ap_field (ap_field),
    .tb_field (tb_field),
    .en_drop  (en_drop)
  );

  remap_aperture u_win (
    .xl_en   (xl_en),
    .ap_order(ap_order),
    .ap_field(ap_field),
    .bus_addr(req_addr),
    .pass    (pass),
    .page_idx(page_idx)
  );

  assign ent_addr  = {tb_field, {PG_SH{1'b0}}} +
                     {{(PA_W-VPN_W-2){1'b0}}, page_idx, 2'b00};
  assign cache_clr = flush || en_drop;

  remap_tcache #(
    .N_WAYS(N_WAYS),
    .TAG_W (VPN_W),
    .DAT_W (ENT_W)
  ) u_tc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cache_clr),
    .look_tag (req_addr[BUS_W-1:PG_SH]),
    .hit      (hit),
    .hit_data (hit_data),
    .fill_en  (fill_en),
    .fill_tag (fill_tag),
    .fill_data(fill_data)
  );

  remap_walker u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_ready    (req_ready),
    .pass         (pass),
    .hit          (hit),
    .hit_data     (hit_data),
    .ent_addr     (ent_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .mem_rsp_ready(mem_rsp_ready),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_coherent (rsp_coherent),
    .rsp_paddr    (rsp_paddr),
    .fill_en      (fill_en),
    .fill_tag     (fill_tag),
    .fill_data    (fill_data)
  );
endmodule

// File: rtl/remap_xlate_chk.sv
module remap_xlate_chk
  import remap_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            rsp_coherent,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready
);
  // R12: a read request holds its address until taken
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R12: never a new read while waiting for data
  a_r12_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  // R12: a response follows an acceptance or a taken memory response
  a_r12_rsp_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid && mem_rsp_ready)));

  // R8: a fault carries no address and no coherent flag
  a_r8_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_paddr == '0) && !rsp_coherent);

  // R6: entry reads are word aligned
  a_r6_aligned_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R3: a read starts only right after a request was accepted
  a_r3_fetch_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(req_valid && req_ready));
endmodule

bind remap_xlate remap_xlate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_coherent (rsp_coherent),
  .rsp_paddr    (rsp_paddr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_ready(mem_rsp_ready)
);

// File: tb/remap_xlate_tb.sv
module remap_xlate_tb;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        flush;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_ready;
  logic        rsp_valid, rsp_fault, rsp_coherent;
  logic [39:0] rsp_paddr;
  logic        mem_req_valid, mem_req_ready;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid, mem_rsp_ready;
  logic [31:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int mem_reads = 0;
  logic [39:0] last_ea = '0;

  // reference state
  bit          m_en = 0;
  int          m_order = 0;
  int          m_field = 0;
  logic [27:0] m_tb = '0;
  logic [19:0] m_tag [4];
  bit          m_vld [4];
  int          m_rr = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  remap_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .flush(flush),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_coherent(rsp_coherent),
    .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_ready(mem_rsp_ready)
  );

  function automatic logic [31:0] entry_fn(input logic [39:0] a);
    logic [31:0] e;
    e[31:12] = a[23:4] ^ 20'hA5C3F;
    e[11:4]  = a[11:4] ^ 8'h5A ^ a[31:24];
    e[3:2]   = 2'b00;
    e[1]     = a[2] ^ a[3];
    e[0]     = (a[6:2] % 5) != 0;
    return e;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
  endtask

  // memory model with random stalls
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid === 1'b1) begin : serve
        logic [39:0] a;
        int d;
        a = mem_req_addr;
        d = $urandom % 3;
        repeat (d) begin
          @(negedge clk);
          chk("R12 request held", {63'd0, mem_req_valid}, 64'd1);
          chk("R12 address stable", {24'd0, mem_req_addr}, {24'd0, a});
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_reads++;
        last_ea = a;
        d = $urandom % 3;
        repeat (d) @(negedge clk);
        chk("R12 waiting for data", {63'd0, mem_rsp_ready}, 64'd1);
        chk("R12 no second read", {63'd0, mem_req_valid}, 64'd0);
        mem_rsp_data  = entry_fn(a);
        mem_rsp_valid = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h90) begin
      if (m_en && !d[0]) model_clear();
      m_en = d[0];
      m_order = int'(d[3:1]);
    end
    if (a == 8'h94) m_field = int'(d[14:0]);
    if (a == 8'h98) m_tb = d[31:4];
  endtask

  task automatic cfg_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_clear();
  endtask

  task automatic run_one(input logic [31:0] a, input string ctx);
    logic [40:0] base, endv, ax;
    bit win_ok, pass, hit;
    logic [19:0] idx;
    logic [39:0] ea, exp_pa;
    logic [31:0] e;
    int reads0, n;
    string rq;
    base = 41'(m_field) << 25;
    endv = base + (41'd1 << (25 + m_order));
    ax = 41'(a);
    win_ok = (m_field != 0) && (endv <= 41'h1_0000_0000);
    pass = m_en && win_ok && (ax >= base) && (ax < endv);
    idx = a[31:12] - base[31:12];
    ea = {m_tb, 12'h000} + {18'd0, idx, 2'b00};
    e = entry_fn(ea);
    hit = 0;
    for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == a[31:12]) hit = 1;
    reads0 = mem_reads;
    n = 0;
    @(negedge clk);
    chk({"R12 ready before ", ctx}, {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    while (rsp_valid !== 1'b1 && n < 60) begin @(negedge clk); n++; end
    if (!m_en) rq = "R5";
    else if (!win_ok) rq = "R4";
    else if (!pass) rq = "R3";
    else if (hit) rq = "R9";
    else if (!e[0]) rq = "R8";
    else rq = "R7";
    rq = {rq, " ", ctx};
    chk({rq, " response seen"}, {63'd0, rsp_valid}, 64'd1);
    if (!pass || hit) begin
      chk({"R12 one-cycle answer ", rq}, 64'(n), 64'd0);
      chk({rq, " no memory read"}, 64'(mem_reads), 64'(reads0));
    end else begin
      chk({"R6 one memory read ", rq}, 64'(mem_reads), 64'(reads0 + 1));
      chk({"R6 entry address ", rq}, {24'd0, last_ea}, {24'd0, ea});
    end
    if (!pass || !e[0]) begin
      chk({rq, " fault"}, {63'd0, rsp_fault}, 64'd1);
      chk({rq, " paddr zero"}, {24'd0, rsp_paddr}, 64'd0);
      chk({rq, " coherent zero"}, {63'd0, rsp_coherent}, 64'd0);
    end else begin
      exp_pa = {e[11:4], e[31:12], a[11:0]};
      chk({rq, " no fault"}, {63'd0, rsp_fault}, 64'd0);
      chk({rq, " paddr"}, {24'd0, rsp_paddr}, {24'd0, exp_pa});
      chk({rq, " coherent"}, {63'd0, rsp_coherent}, {63'd0, e[1]});
      if (!hit) begin
        m_tag[m_rr] = a[31:12];
        m_vld[m_rr] = 1;
        m_rr = (m_rr + 1) % 4;
      end
    end
  endtask

  function automatic logic [31:0] page_addr(input int pg, input int off);
    logic [63:0] v;
    v = (64'(m_field) << 25) + (64'(pg) << 12) + 64'(off);
    return v[31:0];
  endfunction

  initial begin
    int rd0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int rd0, last_pg, sel;
    logic [63:0] t;
    void'($urandom(32'h5EED1234));
    model_clear();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    flush = 1'b0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 req_ready", {63'd0, req_ready}, 64'd1);
    chk("R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R1 mem_req_valid", {63'd0, mem_req_valid}, 64'd0);
    chk("R1 mem_rsp_ready", {63'd0, mem_rsp_ready}, 64'd0);
    rst_n = 1'b1;
    cfg_read(8'h90, v); chk("R1 control reads 0", 64'(v), 64'd0);
    cfg_read(8'h94, v); chk("R1 window reads 0", 64'(v), 64'd0);
    cfg_read(8'h98, v); chk("R1 table reads 0", 64'(v), 64'd0);

    // R2 register layout
    cfg_write(8'h90, 32'h0000_003F);
    cfg_read(8'h90, v); chk("R2 enable clears bits 5:4", 64'(v), 64'h0F);
    cfg_write(8'h90, 32'h0000_0030);
    cfg_read(8'h90, v); chk("R2 disabled keeps bits 5:4", 64'(v), 64'h30);
    cfg_write(8'h94, 32'hFFFF_FFFF);
    cfg_read(8'h94, v); chk("R2 window field width", 64'(v), 64'h7FFF);
    cfg_write(8'h98, 32'hFFFF_FFFF);
    cfg_read(8'h98, v); chk("R2 table field bits", 64'(v), 64'hFFFF_FFF0);
    cfg_read(8'h9C, v); chk("R2 unmapped offset", 64'(v), 64'd0);

    // directed window: base 256 MiB, size 64 MiB
    cfg_write(8'h98, {28'hA5B3C0D, 4'h0});
    cfg_write(8'h94, 32'd8);
    cfg_write(8'h90, 32'h3);
    last_pg = (1 << (13 + m_order)) - 1;
    run_one(page_addr(0, 0), "first byte, invalid entry");
    run_one(page_addr(0, 12), "invalid entry not cached");
    run_one(page_addr(1, 4), "page 1 miss");
    run_one(page_addr(1, 4095), "page 1 hit");
    run_one(page_addr(last_pg, 4095), "last byte in window");
    run_one(page_addr(last_pg + 1, 0), "one past window");
    run_one(page_addr(0, 0) - 32'd1, "one below window");
    for (int p = 2; p <= 6; p++) run_one(page_addr(p, p * 8), "fill sweep");
    run_one(page_addr(1, 0), "evicted page");
    run_one(page_addr(6, 0), "recent page");
    rd0 = mem_reads;
    run_one(page_addr(6, 100), "before flush");
    chk("R9 cached page no read", 64'(mem_reads), 64'(rd0));
    pulse_flush();
    rd0 = mem_reads;
    run_one(page_addr(6, 100), "after flush");
    chk("R10 flush forces refetch", 64'(mem_reads), 64'(rd0 + 1));
    cfg_write(8'h90, 32'h2);
    run_one(page_addr(6, 0), "disabled");
    cfg_write(8'h90, 32'h3);
    rd0 = mem_reads;
    run_one(page_addr(6, 0), "after enable drop");
    chk("R11 enable drop forces refetch", 64'(mem_reads), 64'(rd0 + 1));
    cfg_write(8'h94, 32'd0);
    run_one(32'h0000_1000, "zero base field");
    cfg_write(8'h94, 32'd8);
    cfg_write(8'h90, 32'hF);
    run_one(page_addr(1, 0), "window past 4 GiB");
    cfg_write(8'h94, 32'd64);
    cfg_write(8'h90, 32'hD);
    run_one(32'hFFFF_FFFC, "window ends at 4 GiB");
    run_one(32'h7FFF_FFFF, "below high window");

    // random phase
    for (int it = 0; it < 400; it++) begin
      if (it % 40 == 0) begin
        int o, f;
        o = $urandom % 7;
        f = 1 + ($urandom % (128 - (1 << o)));
        cfg_write(8'h98, $urandom);
        cfg_write(8'h94, 32'(f));
        cfg_write(8'h90, {28'd0, 3'(o), 1'b1} | ($urandom & 32'h30));
      end
      if ($urandom % 25 == 0) pulse_flush();
      last_pg = (1 << (13 + m_order)) - 1;
      sel = $urandom % 8;
      if (sel < 5) t = 64'(page_addr(sel, $urandom % 4096));
      else if (sel == 5) t = 64'(page_addr(last_pg, $urandom % 4096));
      else if (sel == 6 || ((64'(m_field) << 25) + (64'd1 << (25 + m_order)) >= 64'h1_0000_0000))
        t = (64'(m_field) << 25) - 64'd1 - 64'($urandom % 8192);
      else
        t = (64'(m_field) << 25) + (64'd1 << (25 + m_order)) + 64'($urandom % 8192);
      run_one(t[31:0], "random");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule